// File: doc/BRIEF.md
# Controller Hand-off Wait Timer

When the controller role on a serial bus passes from one device to another, there is a settling time that must run out before anyone pulls the data line low. The incoming controller must wait this time before it issues its start. The outgoing active controller must wait the same time while it watches the newcomer, and only then may it test the newcomer by driving the data line low. This block measures that one wait for both sides. It raises a single-cycle done pulse when the wait has elapsed.

The length of the wait is an 8-bit availability count multiplied by a factor. A 2-bit activity-state selector chooses the factor from four values: 1, 100, 2000 or 50000 kernel clocks per count unit. A prescaler reloads with the chosen factor and ticks an 8-bit down-counter. The selector is a small register inside the block. It accepts writes only while the role input says the block is the active controller. When a start strobe arrives, the block takes a snapshot of both the selector and the count. Later changes to either therefore cannot stretch or shorten a wait that is already running. An abort input drops the wait and returns the block to idle without a done pulse.

Top module: `handoff_wait_timer`

## Requirements
- R1: With selector code 00, done_o rises exactly N clock edges after the edge that samples start_i with avail_cnt = N (N from 1 to 255).
- R2: With selector code 01 the wait is N × 100 clock edges.
- R3: With selector code 10 the wait is N × 2000 clock edges.
- R4: With selector code 11 the wait is N × 50000 clock edges.
- R5: done_o is high for exactly one cycle. busy_o is high from the edge after start until the edge that raises done_o, and it is low while done_o is high.
- R6: A selector write (sel_we = 1) is ignored while role_active = 0. A later wait uses the previously held code.
- R7: The selector and count are captured on the start edge. Changing avail_cnt, or writing the selector while a wait runs, does not alter that wait. A selector write made during a wait with role_active = 1 is used by the next wait.
- R8: abort_i clears busy_o on the next edge, and no done_o pulse follows for the aborted wait. abort_i takes priority over start_i.
- R9: start_i is ignored while busy_o is high.
- R10: avail_cnt = 0 gives a wait of one clock edge.
- R11: After reset, busy_o and done_o are low and the selector holds code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_active | input | 1 | 1 while the block acts as the active controller; gates selector writes |
| sel_we | input | 1 | Selector write strobe |
| sel_wdata | input | 2 | Selector code to write (00 ×1, 01 ×100, 10 ×2000, 11 ×50000) |
| avail_cnt | input | 8 | Availability base count |
| start_i | input | 1 | Start-wait strobe, honoured only when idle |
| abort_i | input | 1 | Abandon the wait without a done pulse |
| busy_o | output | 1 | A wait is running |
| done_o | output | 1 | One-cycle pulse when the wait has elapsed |

## Verification
Each result falls due a fixed number of edges after the edge that samples start_i: N × factor edges for a normal wait, and one edge for a zero count. busy_o changes on the edge right after start or abort. For every start, the bench works out the exact edge number at which done_o must appear and queues it. A monitor samples on the falling edge, so it sees the values registered at the preceding rising edge. At each done pulse it compares the current edge number with the queued value. A done pulse that nothing queued is reported as a failure, which covers abort and ignored restarts.

// File: rtl/handoff_wait_timer.sv
module handoff_wait_timer #(
  parameter int CNT_W = 8,
  parameter int MULT0 = 1,
  parameter int MULT1 = 100,
  parameter int MULT2 = 2000,
  parameter int MULT3 = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_active,
  input  logic             sel_we,
  input  logic [1:0]       sel_wdata,
  input  logic [CNT_W-1:0] avail_cnt,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int PRE_W = $clog2(MULT3 + 1);

  logic [1:0]       sel_q, sel_run_q;
  logic [PRE_W-1:0] pre_q, reload_run;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  function automatic logic [PRE_W-1:0] reload_of(input logic [1:0] s);
    case (s)
      2'b00:   reload_of = PRE_W'(MULT0 - 1);
      2'b01:   reload_of = PRE_W'(MULT1 - 1);
      2'b10:   reload_of = PRE_W'(MULT2 - 1);
      default: reload_of = PRE_W'(MULT3 - 1);
    endcase
  endfunction

  assign reload_run = reload_of(sel_run_q);
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    sel_q <= 2'b00;
    else if (sel_we && role_active) sel_q <= sel_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      pre_q     <= '0;
      sel_run_q <= 2'b00;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (start_i) begin
          busy_q    <= 1'b1;
          sel_run_q <= sel_q;
          if (avail_cnt == '0) begin
            cnt_q <= CNT_W'(1);
            pre_q <= '0;
          end else begin
            cnt_q <= avail_cnt;
            pre_q <= reload_of(sel_q);
          end
        end
      end else if (pre_q == '0) begin
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          pre_q <= reload_run;
        end
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!done_o && !busy_o));
  assert_sel_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !role_active |=> $stable(sel_q));
  assert_count_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cnt_q <= $past(cnt_q)));
  assert_pre_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (pre_q <= reload_run));
endmodule

// File: tb/tb_handoff_wait_timer.sv
`timescale 1ns/1ps
module tb_handoff_wait_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_active = 1'b0, sel_we = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic [7:0] avail_cnt = 8'd0;
  logic       busy_o, done_o;

  int cyc = 0, checks = 0, fails = 0, dones = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  handoff_wait_timer dut (
    .clk(clk), .rst_n(rst_n), .role_active(role_active), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .avail_cnt(avail_cnt), .start_i(start_i),
    .abort_i(abort_i), .busy_o(busy_o), .done_o(done_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic role, input logic [1:0] code);
    @(negedge clk);
    role_active = role; sel_we = 1'b1; sel_wdata = code;
    @(negedge clk);
    sel_we = 1'b0; role_active = 1'b1;
  endtask

  task automatic launch(input string req, input int n, input int mult, input bit expect_done);
    @(negedge clk);
    avail_cnt = 8'(n); start_i = 1'b1;
    if (expect_done) begin
      exp_q.push_back(cyc + 1 + ((n == 0) ? 1 : n * mult));
      tag_q.push_back(req);
    end
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      dones++;
      if (exp_q.size() == 0) begin
        check("R8/R9 unexpected done", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, cyc, e);
        check("R5 busy low with done", int'(busy_o), 0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 busy after reset", int'(busy_o), 0);
    check("R11 done after reset", int'(done_o), 0);
    rst_n = 1'b1;
    role_active = 1'b1;

    launch("R11 default selector 00", 5, 1, 1); drain();
    write_sel(1'b1, 2'b00);
    launch("R1 x1 n=255", 255, 1, 1);
    repeat (10) @(negedge clk);
    check("R5 busy during wait", int'(busy_o), 1);
    drain();
    write_sel(1'b1, 2'b01); launch("R2 x100", 3, 100, 1); drain();
    write_sel(1'b1, 2'b10); launch("R3 x2000", 2, 2000, 1); drain();
    write_sel(1'b1, 2'b11); launch("R4 x50000", 1, 50000, 1); drain();

    write_sel(1'b1, 2'b00);
    write_sel(1'b0, 2'b11);
    launch("R6 write ignored when not active", 4, 1, 1); drain();

    write_sel(1'b1, 2'b01);
    launch("R7 snapshot held", 2, 100, 1);
    repeat (5) @(negedge clk);
    avail_cnt = 8'd9;
    write_sel(1'b1, 2'b00);
    drain();
    launch("R7 new selector next wait", 1, 1, 1); drain();

    launch("R9 restart ignored", 10, 1, 1);
    repeat (2) @(negedge clk);
    launch("R9 second start", 1, 1, 0);
    drain();

    begin
      automatic int d0 = dones;
      launch("R8 aborted", 50, 1, 0);
      repeat (4) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check("R8 busy cleared", int'(busy_o), 0);
      repeat (60) @(negedge clk);
      check("R8 no done after abort", dones - d0, 0);
      @(negedge clk);
      abort_i = 1'b1; start_i = 1'b1; avail_cnt = 8'd1;
      @(negedge clk);
      abort_i = 1'b0; start_i = 1'b0;
      check("R8 abort beats start", int'(busy_o), 0);
      repeat (5) @(negedge clk);
      check("R8 no done after abort+start", dones - d0, 0);
    end

    launch("R10 zero count", 0, 1, 1); drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule